// File: doc/BRIEF.md
# Memory-Mapped Quad Serial Flash Read Engine

This block lets an on-chip requester read an external serial NOR flash as if it were plain memory. A read request on a valid/ready port becomes one complete flash read transaction in hardware, with no software step. The requester can be an instruction fetch or a data load; the block handles both the same way. One read is in flight at a time. The engine returns one 32-bit word per request with a single-cycle response pulse.

On the flash side the block drives six signals: an active-low chip select, a serial clock at half the system clock, and four data lines. Each data line has a separate output value, output enable and input. A transaction has four phases in order. The 8-bit opcode goes out serially on line 0. The address goes out on all four lines, a nibble per serial cycle. A run of turnaround cycles follows, with every line released. Then eight data nibbles come back on all four lines. A configuration input selects 24-bit or 32-bit addressing for each request. The wider mode is for devices above 128 Mbit.

Top module: `qspi_xip_reader`

## Requirements
- R1: `req_ready` is high only while the engine is idle with chip select high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the post-transaction gap has ended, so a held `req_valid` waits.
- R2: The serial clock is low whenever chip select is high. Chip select falls on the acceptance edge with the serial clock low, and the first serial clock rise comes one system clock later. While chip select is low, the serial clock toggles on every system clock.
- R3: The opcode takes 8 serial cycles, most significant bit first, on data line 0 only (`flash_io_oe` = 4'b0001). It is 0xEB when `addr4_en` is 0 at acceptance and 0xEC when `addr4_en` is 1 at acceptance. `flash_io_oe` only ever takes the values 4'b0000, 4'b0001 or 4'b1111.
- R4: With `addr4_en` = 0 at acceptance, the address phase is 6 serial cycles on all four lines (`flash_io_oe` = 4'b1111). It carries `req_addr[23:0]`, most significant nibble first, with nibble bit k on line k.
- R5: With `addr4_en` = 1 at acceptance, the address phase is 8 serial cycles carrying all 32 bits of `req_addr`, most significant nibble first. The mode is captured at acceptance, and later changes on `addr4_en` do not affect the transaction in flight.
- R6: After the address come exactly DUMMY_CYC serial cycles (default 6) and then 8 data cycles. All output enables are low throughout both phases. A 24-bit transaction therefore has 28 serial clock rises and a 32-bit one has 30.
- R7: Data line k carries bit k of each nibble, and the high nibble of each byte arrives first. The n-th byte received (n = 0..3) lands in `rsp_data[8n+7:8n]`.
- R8: While chip select stays low, outgoing line values and enables change only on system clock edges where the serial clock falls. An incoming nibble is captured while the serial clock is high, on the edge that ends the high half.
- R9: `rsp_valid` is a one-cycle pulse. It is raised on the same edge on which chip select returns high, and that edge comes exactly 2×(8 + address cycles + DUMMY_CYC + 8) system clocks after the acceptance edge (56 for 24-bit, 60 for 32-bit at default settings).
- R10: Between two transactions chip select stays high for at least 4 system clocks (2 serial clock periods).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 32 | Byte address of the word to read |
| addr4_en | input | 1 | 1 selects 32-bit flash addressing for this request |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | 32 | Read word, first received byte in bits 7:0 |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock, idles low |
| flash_io_o | output | 4 | Values driven onto the four data lines |
| flash_io_oe | output | 4 | Per-line output enable, 1 = engine drives |
| flash_io_i | input | 4 | Values read from the four data lines |

## Verification
The completion of one read and the arrival of the next request can fall in the same cycle. The response pulse and the chip-select release share an edge, and a requester that keeps `req_valid` high is already waiting then. The bench provokes this by holding `req_valid` high across back-to-back requests. It then judges three things: the engine waits out the chip-select gap before it accepts, each response carries the word for its own address at exactly the computed edge, and the next transaction's opcode and address, as seen by the flash model, belong to the new request. The bench also flips `addr4_en` while a read is in flight and checks that the serial clock count and the opcode follow the mode captured at acceptance.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam int WORD_W       = 32;
    localparam int NIBS_PER_WRD = WORD_W / 4;
    localparam int CMD_BITS     = 8;
    localparam int ADDR_NIBS_3B = 6;
    localparam int ADDR_NIBS_4B = 8;
    localparam int GAP_CLKS     = 4;

    // Bit position in the response word of received nibble n (0..7):
    // bytes little-endian, high nibble of each byte first.
    function automatic logic [4:0] rx_pos(input logic [2:0] n);
        return {n[2:1], ~n[0], 2'b00};
    endfunction

    // Nibble of a word, index 0 = most significant nibble.
    function automatic logic [3:0] tx_nib(input logic [WORD_W-1:0] w, input logic [2:0] idx);
        logic [WORD_W-1:0] s;
        s = w >> {3'd7 - idx, 2'b00};
        return s[3:0];
    endfunction

endpackage

// File: rtl/qxr_seq.sv
module qxr_seq
    import qxr_pkg::*;
#(
    parameter int DUMMY_CYC = 6,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mode4_i,
    output phase_e           state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             mode4_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             cap_stb_o,
    output logic             done_o
);

    phase_e           state;
    phase_e           nxt_state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             ph;
    logic             mode4;
    logic             sclk;
    logic             cs_n;
    logic             done;

    always_comb begin
        nxt_state = PH_IDLE;
        last_cnt  = CNT_W'(CMD_BITS - 1);
        case (state)
            PH_CMD: begin
                last_cnt  = CNT_W'(CMD_BITS - 1);
                nxt_state = PH_ADDR;
            end
            PH_ADDR: begin
                last_cnt  = mode4 ? CNT_W'(ADDR_NIBS_4B - 1) : CNT_W'(ADDR_NIBS_3B - 1);
                nxt_state = PH_DUMMY;
            end
            PH_DUMMY: begin
                last_cnt  = CNT_W'(DUMMY_CYC - 1);
                nxt_state = PH_DATA;
            end
            PH_DATA: begin
                last_cnt  = CNT_W'(NIBS_PER_WRD - 1);
                nxt_state = PH_GAP;
            end
            default: begin
                last_cnt  = CNT_W'(GAP_CLKS - 1);
                nxt_state = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cnt   <= '0;
            ph    <= 1'b0;
            mode4 <= 1'b0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (start_i) begin
                        state <= PH_CMD;
                        cnt   <= '0;
                        ph    <= 1'b0;
                        cs_n  <= 1'b0;
                        mode4 <= mode4_i;
                    end
                end
                PH_GAP: begin
                    if (cnt == last_cnt) begin
                        state <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (!ph) begin
                        sclk <= 1'b1;
                        ph   <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        ph   <= 1'b0;
                        if (cnt == last_cnt) begin
                            cnt   <= '0;
                            state <= nxt_state;
                            if (state == PH_DATA) begin
                                cs_n <= 1'b1;
                                done <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign state_o   = state;
    assign cnt_o     = cnt;
    assign mode4_o   = mode4;
    assign sclk_o    = sclk;
    assign cs_n_o    = cs_n;
    assign cap_stb_o = (state == PH_DATA) && ph;
    assign done_o    = done;

    // Assertion support: cycles spent with chip select high, saturating.
    logic [2:0] hi_run;
    logic       seen_tx;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= '0;
            seen_tx <= 1'b0;
        end else begin
            if (done) seen_tx <= 1'b1;
            if (cs_n) hi_run <= (hi_run == 3'd7) ? hi_run : hi_run + 1'b1;
            else      hi_run <= '0;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && seen_tx) |-> (hi_run >= 3'd4));

endmodule

// File: rtl/qxr_txmux.sv
module qxr_txmux
    import qxr_pkg::*;
(
    input  phase_e            state_i,
    input  logic [2:0]        cnt_i,
    input  logic              mode4_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [7:0]        opcode_i,
    output logic [3:0]        io_o,
    output logic [3:0]        io_oe
);

    logic [2:0] bit_idx;
    logic [2:0] nib_idx;

    assign bit_idx = 3'(CMD_BITS - 1) - cnt_i;
    assign nib_idx = cnt_i + (mode4_i ? 3'd0 : 3'(ADDR_NIBS_4B - ADDR_NIBS_3B));

    always_comb begin
        io_o  = 4'b0000;
        io_oe = 4'b0000;
        case (state_i)
            PH_CMD: begin
                io_o  = {3'b000, opcode_i[bit_idx]};
                io_oe = 4'b0001;
            end
            PH_ADDR: begin
                io_o  = tx_nib(addr_i, nib_idx);
                io_oe = 4'b1111;
            end
            default: begin
                io_o  = 4'b0000;
                io_oe = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/qxr_rxasm.sv
module qxr_rxasm
    import qxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic [2:0]        idx_i,
    input  logic [3:0]        nib_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word <= '0;
        end else if (stb_i) begin
            word[rx_pos(idx_i) +: 4] <= nib_i;
        end
    end

    assign word_o = word;

endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader
    import qxr_pkg::*;
#(
    parameter logic [7:0] OPC_3B    = 8'hEB,
    parameter logic [7:0] OPC_4B    = 8'hEC,
    parameter int         DUMMY_CYC = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        addr4_en,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        flash_cs_n,
    output logic        flash_sclk,
    output logic [3:0]  flash_io_o,
    output logic [3:0]  flash_io_oe,
    input  logic [3:0]  flash_io_i
);

    localparam int MAX_CNT = (DUMMY_CYC > NIBS_PER_WRD) ? DUMMY_CYC : NIBS_PER_WRD;
    localparam int CNT_W   = $clog2(MAX_CNT);

    phase_e            state;
    logic [CNT_W-1:0]  cnt;
    logic              mode4;
    logic              cap_stb;
    logic              start;
    logic [WORD_W-1:0] addr_q;

    assign req_ready = (state == PH_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)        addr_q <= '0;
        else if (start) addr_q <= req_addr;
    end

    qxr_seq #(
        .DUMMY_CYC (DUMMY_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .mode4_i   (addr4_en),
        .state_o   (state),
        .cnt_o     (cnt),
        .mode4_o   (mode4),
        .sclk_o    (flash_sclk),
        .cs_n_o    (flash_cs_n),
        .cap_stb_o (cap_stb),
        .done_o    (rsp_valid)
    );

    qxr_txmux u_tx (
        .state_i  (state),
        .cnt_i    (cnt[2:0]),
        .mode4_i  (mode4),
        .addr_i   (addr_q),
        .opcode_i (mode4 ? OPC_4B : OPC_3B),
        .io_o     (flash_io_o),
        .io_oe    (flash_io_oe)
    );

    qxr_rxasm u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (start),
        .stb_i  (cap_stb),
        .idx_i  (cnt[2:0]),
        .nib_i  (flash_io_i),
        .word_o (rsp_data)
    );

    p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !flash_cs_n |-> !req_ready);
    p_oe_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (flash_io_oe == 4'b0000) || (flash_io_oe == 4'b0001) || (flash_io_oe == 4'b1111));
    p_oe_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ((state == PH_DUMMY) || (state == PH_DATA)) |-> (flash_io_oe == 4'b0000));
    p_oe_cs_r6: assert property (@(posedge clk) disable iff (rst)
        (flash_io_oe != 4'b0000) |-> !flash_cs_n);
    p_fall_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (!flash_cs_n && $past(!flash_cs_n) && !$stable(flash_io_o)) |-> $fell(flash_sclk));

endmodule

// File: tb/qspi_xip_reader_bench.sv
module qspi_xip_reader_bench;

    localparam int DUMMY = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        addr4_en = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        cs_n;
    logic        sclk;
    logic [3:0]  io_o;
    logic [3:0]  io_oe;
    logic [3:0]  io_i;
    logic [3:0]  fdrv = 4'b0000;

    int errors = 0;
    int checks = 0;
    longint cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign io_i = (io_oe & io_o) | (~io_oe & fdrv);

    qspi_xip_reader u_qspi_xip_reader (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .addr4_en    (addr4_en),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .flash_cs_n  (cs_n),
        .flash_sclk  (sclk),
        .flash_io_o  (io_o),
        .flash_io_oe (io_oe),
        .flash_io_i  (io_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flash content: one byte per address.
    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic int unsigned alen_of(input logic [7:0] op);
        return (op == 8'hEC) ? 8 : 6;
    endfunction

    // ---------------- flash model ----------------
    int unsigned rc = 0;
    logic [7:0]  m_op = '0;
    logic [31:0] m_ad = '0;
    bit          m_oe_err = 1'b0;
    int unsigned last_rc = 0;
    logic [7:0]  last_op = '0;
    logic [31:0] last_ad = '0;
    bit          last_oe_err = 1'b0;

    always @(negedge cs_n) begin
        rc = 0; m_op = '0; m_ad = '0; m_oe_err = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rc < 8) begin
                if (io_oe !== 4'b0001) m_oe_err = 1'b1;
                m_op = {m_op[6:0], io_o[0]};
            end else if (rc < 8 + alen_of(m_op)) begin
                if (io_oe !== 4'b1111) m_oe_err = 1'b1;
                m_ad = {m_ad[27:0], io_o};
            end else begin
                if (io_oe !== 4'b0000) m_oe_err = 1'b1;
            end
            rc++;
        end
    end

    always @(negedge sclk) begin
        int unsigned base;
        int unsigned n;
        logic [7:0]  b;
        if (!cs_n) begin
            base = 8 + alen_of(m_op) + DUMMY;
            if (rc >= base && rc < base + 8) begin
                n = rc - base;
                b = fbyte(m_ad + 32'(n / 2));
                fdrv = (n % 2 == 0) ? b[7:4] : b[3:0];
            end
        end
    end

    always @(posedge cs_n) begin
        last_rc = rc; last_op = m_op; last_ad = m_ad; last_oe_err = m_oe_err;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] data;
        logic [31:0] eff;
        logic        m;
        longint      cyc;
    } exp_t;
    exp_t q[$];

    task automatic issue(input logic [31:0] a, input logic m, input bit hold);
        exp_t e;
        int   n;
        req_addr  = a;
        addr4_en  = m;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        e.m    = m;
        e.eff  = m ? a : {8'h00, a[23:0]};
        e.data = {fbyte(e.eff + 3), fbyte(e.eff + 2), fbyte(e.eff + 1), fbyte(e.eff)};
        n      = 8 + (m ? 8 : 6) + DUMMY + 8;
        e.cyc  = cyc + 1 + 2 * n;
        q.push_back(e);
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        addr4_en = ~m;   // R5: must not affect the read in flight
    endtask

    // ---------------- monitor ----------------
    bit   mon_on = 1'b0;
    bit   p_cs = 1'b1, p_sclk = 1'b0, p_rsp = 1'b0;
    logic [3:0] p_o = '0, p_oe = '0;
    bit   e_r1 = 0, e_r2 = 0, e_r8 = 0, had_tx = 0;
    int   hi_run = 0;

    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (!cs_n && req_ready) e_r1 = 1;
            if (p_cs && !cs_n && sclk) e_r2 = 1;
            if (!p_cs && !cs_n && (sclk == p_sclk)) e_r2 = 1;
            if (cs_n && sclk) e_r2 = 1;
            if (!p_cs && !cs_n && ((io_o != p_o) || (io_oe != p_oe)) && !(p_sclk && !sclk)) e_r8 = 1;
            if (p_cs && !cs_n && had_tx) chk("R10 cs high gap>=4", 64'(hi_run >= 4), 64'd1);
            hi_run = cs_n ? hi_run + 1 : 0;
            if (p_rsp) chk("R9 pulse width", 64'(rsp_valid), 64'd0);
            if (rsp_valid) begin
                had_tx = 1;
                if (q.size() == 0) begin
                    chk("R9 unexpected response", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    chk("R7 word", 64'(rsp_data), 64'(e.data));
                    chk("R9 response edge", 64'(cyc), 64'(e.cyc));
                    chk("R9 cs high with response", 64'(cs_n), 64'd1);
                    chk("R3 opcode", 64'(last_op), e.m ? 64'hEC : 64'hEB);
                    chk(e.m ? "R5 address" : "R4 address", 64'(last_ad), 64'(e.eff));
                    chk("R6 sclk rises", 64'(last_rc), 64'(8 + (e.m ? 8 : 6) + DUMMY + 8));
                    chk("R6 enables per phase", 64'(last_oe_err), 64'd0);
                    chk("R2 sclk/cs timing", 64'(e_r2), 64'd0);
                    chk("R8 change on falling edge", 64'(e_r8), 64'd0);
                    chk("R1 ready low while busy", 64'(e_r1), 64'd0);
                end
                e_r1 = 0; e_r2 = 0; e_r8 = 0;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_rsp = rsp_valid; p_o = io_o; p_oe = io_oe;
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R2 cs high after reset", 64'(cs_n), 64'd1);
        chk("R2 sclk low after reset", 64'(sclk), 64'd0);
        chk("R6 enables off after reset", 64'(io_oe), 64'd0);
        chk("R9 no response after reset", 64'(rsp_valid), 64'd0);
        mon_on = 1'b1;

        issue(32'h0000_0000, 1'b0, 1'b0);
        issue(32'h12AB_CDEF, 1'b0, 1'b0);
        issue(32'h12AB_CDEF, 1'b1, 1'b0);
        issue(32'hFFFF_FFFC, 1'b1, 1'b1);   // held: back-to-back
        issue(32'h00FF_FFF0, 1'b0, 1'b1);
        issue(32'hA5A5_5A5A, 1'b1, 1'b1);
        issue(32'h0000_0104, 1'b0, 1'b0);

        for (int i = 0; i < 400 && q.size() != 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R9 all responses returned", 64'(q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            summary();
        end
    end

endmodule